// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a RISC core whose register set slides with each procedure call. Software always addresses 32 registers with a 5-bit index. Indexes 0 to 7 are globals shared by every frame. Indexes 8 to 31 form the current frame: 8 outgoing registers (8..15), 8 private locals (16..23) and 8 incoming registers (24..31). The physical array holds `8 + 16*NWIN` words. Each window owns an outgoing group and a local group. Its incoming group is the outgoing group of the window one position above it, so a caller's outgoing arguments appear as the callee's incoming values without any copying.

A save request moves the current window pointer down by one and a restore moves it up by one. Both wrap modulo the window count. A per-window invalid mask tells the block which windows may not be entered. A save or restore that targets a marked window leaves the pointer where it is and raises an overflow or underflow pulse. Spill and fill handling belongs to the surrounding core. There are two combinational read ports and one write port that is clocked. A read of the register being written in the same cycle returns the incoming data. All three addresses in a cycle are translated with the pointer value held before any save or restore in that cycle takes effect.

Top module: `wrf_top`

## Requirements
- R1: Indexes 1 to 7 address the same physical registers whatever the window pointer holds.
- R2: Index 0 reads as zero on both read ports. A write to index 0 changes no register.
- R3: An accepted save sets the pointer to `cwp-1`, with 0 going to `NWIN-1`. An accepted restore sets it to `cwp+1`, with `NWIN-1` going to 0. The new value is visible on `cwp_o` from the next cycle.
- R4: After a save, indexes 24+k of the callee read what the caller last wrote to index 8+k. After the matching restore, index 8+k reads what the callee wrote to 24+k (k = 0..7).
- R5: Locals (indexes 16..23) belong to one window only. Writes made to locals in another window leave them unchanged.
- R6: A save whose target window has its bit set in `wim_i` (bit i stands for window i) is refused. The pointer keeps its value and `ovf_o` is high for exactly the following cycle.
- R7: A restore whose target window has its bit set in `wim_i` is refused. The pointer keeps its value and `unf_o` is high for exactly the following cycle.
- R8: When a read port addresses the physical register being written in the same cycle, it returns `wr_data`.
- R9: A cycle with both `save_i` and `restore_i` high leaves the pointer unchanged and raises neither flag.
- R10: After reset the pointer is 0, both flags are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_addr_a | input | 5 | Architectural index for read port A |
| rd_data_a | output | XLEN | Read port A data (combinational) |
| rd_addr_b | input | 5 | Architectural index for read port B |
| rd_data_b | output | XLEN | Read port B data (combinational) |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Architectural index for the write |
| wr_data | input | XLEN | Write data |
| save_i | input | 1 | Request to move to the callee window |
| restore_i | input | 1 | Request to move back to the caller window |
| wim_i | input | NWIN | Invalid-window mask, bit i for window i |
| cwp_o | output | $clog2(NWIN) | Current window pointer |
| ovf_o | output | 1 | Refused-save pulse |
| unf_o | output | 1 | Refused-restore pulse |

## Verification
A corrupted window pointer shows on `cwp_o` in the cycle after the save or restore that caused it. It also shows on the data ports as soon as a windowed index is read, because the read returns a neighbouring window's value. A bad translation of the shared group shows up when a callee reads its incoming registers right after a save. A faulty local mapping shows up only after a full save and restore round trip, when the caller reads back its own local. A broken mask decision shows as a moved pointer, or as a missing or stray flag pulse, one cycle after the request.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
    localparam int ARCH_W   = 5;
    localparam int GRP_SZ   = 8;
    localparam int WIN_SPAN = 2 * GRP_SZ;
    typedef logic [ARCH_W-1:0] arch_idx_t;
endpackage

// File: rtl/wrf_xlate.sv
module wrf_xlate
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN),
    parameter int PW   = $clog2(GRP_SZ + WIN_SPAN * NWIN)
) (
    input  arch_idx_t        arch_idx,
    input  logic [CW-1:0]    cwp,
    output logic [PW-1:0]    phys_idx
);
    logic [CW-1:0] caller_win;
    int            idx_i;

    always_comb begin
        caller_win = (cwp == CW'(NWIN - 1)) ? '0 : cwp + CW'(1);
        idx_i      = int'(arch_idx);
        if (idx_i < GRP_SZ)
            phys_idx = PW'(idx_i);
        else if (idx_i < 3 * GRP_SZ)
            phys_idx = PW'(int'(cwp) * WIN_SPAN + idx_i);
        else
            phys_idx = PW'(int'(caller_win) * WIN_SPAN + idx_i - WIN_SPAN);
    end
endmodule

// File: rtl/wrf_wptr.sv
module wrf_wptr #(
    parameter int NWIN = 8,
    parameter int CW   = $clog2(NWIN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            save_i,
    input  logic            restore_i,
    input  logic [NWIN-1:0] wim_i,
    output logic [CW-1:0]   cwp_o,
    output logic            ovf_o,
    output logic            unf_o
);
    typedef struct packed {
        logic [CW-1:0] cwp;
        logic          ovf;
        logic          unf;
    } ptr_t;

    ptr_t          st_d, st_q;
    logic [CW-1:0] dn_win, up_win;

    always_comb begin
        dn_win = (st_q.cwp == '0) ? CW'(NWIN - 1) : st_q.cwp - CW'(1);
        up_win = (st_q.cwp == CW'(NWIN - 1)) ? '0 : st_q.cwp + CW'(1);
        st_d     = st_q;
        st_d.ovf = 1'b0;
        st_d.unf = 1'b0;
        if (save_i && !restore_i) begin
            if (wim_i[dn_win]) st_d.ovf = 1'b1;
            else               st_d.cwp = dn_win;
        end else if (restore_i && !save_i) begin
            if (wim_i[up_win]) st_d.unf = 1'b1;
            else               st_d.cwp = up_win;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cwp_o = st_q.cwp;
    assign ovf_o = st_q.ovf;
    assign unf_o = st_q.unf;

    a_r3_cwp_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        int'(st_q.cwp) < NWIN);

    a_r3_save_step: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && !restore_i && !wim_i[dn_win]) |=>
        (st_q.cwp == (($past(st_q.cwp) == '0) ? CW'(NWIN - 1) : $past(st_q.cwp) - CW'(1))));

    a_r3_restore_step: assert property (@(posedge clk) disable iff (!rst_n)
        (restore_i && !save_i && !wim_i[up_win]) |=>
        (st_q.cwp == (($past(st_q.cwp) == CW'(NWIN - 1)) ? '0 : $past(st_q.cwp) + CW'(1))));

    a_r6_ovf_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> $stable(cwp_o));

    a_r7_unf_holds_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        unf_o |-> $stable(cwp_o));

    a_r9_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ovf_o, unf_o}));

    a_r9_both_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (save_i && restore_i) |=> ($stable(cwp_o) && !ovf_o && !unf_o));
endmodule

// File: rtl/wrf_array.sv
module wrf_array #(
    parameter int NPHYS = 136,
    parameter int PW    = $clog2(NPHYS),
    parameter int XLEN  = 32,
    parameter int NRD   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      we,
    input  logic [PW-1:0]             waddr,
    input  logic [XLEN-1:0]           wdata,
    input  logic [NRD-1:0][PW-1:0]    raddr,
    output logic [NRD-1:0][XLEN-1:0]  rdata
);
    logic [XLEN-1:0] mem_d [NPHYS];
    logic [XLEN-1:0] mem_q [NPHYS];

    always_comb begin
        for (int i = 0; i < NPHYS; i++) mem_d[i] = mem_q[i];
        if (we && int'(waddr) < NPHYS) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPHYS; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < NPHYS; i++) mem_q[i] <= mem_d[i];
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        always_comb begin
            if (we && raddr[p] == waddr)
                rdata[p] = wdata;
            else if (int'(raddr[p]) < NPHYS)
                rdata[p] = mem_q[raddr[p]];
            else
                rdata[p] = '0;
        end
    end

    a_r8_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/wrf_top.sv
module wrf_top
    import wrf_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [4:0]               rd_addr_a,
    output logic [XLEN-1:0]          rd_data_a,
    input  logic [4:0]               rd_addr_b,
    output logic [XLEN-1:0]          rd_data_b,
    input  logic                     wr_en,
    input  logic [4:0]               wr_addr,
    input  logic [XLEN-1:0]          wr_data,
    input  logic                     save_i,
    input  logic                     restore_i,
    input  logic [NWIN-1:0]          wim_i,
    output logic [$clog2(NWIN)-1:0]  cwp_o,
    output logic                     ovf_o,
    output logic                     unf_o
);
    localparam int NPHYS = GRP_SZ + WIN_SPAN * NWIN;
    localparam int PW    = $clog2(NPHYS);
    localparam int CW    = $clog2(NWIN);
    localparam int NPORT = 3;

    logic [CW-1:0]               cwp_q;
    arch_idx_t [NPORT-1:0]       arch_sel;
    logic [NPORT-1:0][PW-1:0]    phys_sel;
    logic [1:0][PW-1:0]          rd_phys;
    logic [1:0][XLEN-1:0]        rd_raw;
    logic                        arr_we;

    assign arch_sel = {wr_addr, rd_addr_b, rd_addr_a};

    wrf_wptr #(.NWIN(NWIN), .CW(CW)) u_wptr (
        .clk(clk), .rst_n(rst_n), .save_i(save_i), .restore_i(restore_i),
        .wim_i(wim_i), .cwp_o(cwp_q), .ovf_o(ovf_o), .unf_o(unf_o)
    );

    for (genvar g = 0; g < NPORT; g++) begin : g_xl
        wrf_xlate #(.NWIN(NWIN), .CW(CW), .PW(PW)) u_xl (
            .arch_idx(arch_sel[g]), .cwp(cwp_q), .phys_idx(phys_sel[g])
        );
    end

    assign arr_we  = wr_en && (wr_addr != '0);
    assign rd_phys = {phys_sel[1], phys_sel[0]};

    wrf_array #(.NPHYS(NPHYS), .PW(PW), .XLEN(XLEN), .NRD(2)) u_arr (
        .clk(clk), .rst_n(rst_n), .we(arr_we), .waddr(phys_sel[2]),
        .wdata(wr_data), .raddr(rd_phys), .rdata(rd_raw)
    );

    assign rd_data_a = (rd_addr_a == '0) ? '0 : rd_raw[0];
    assign rd_data_b = (rd_addr_b == '0) ? '0 : rd_raw[1];
    assign cwp_o     = cwp_q;

    a_r2_phys0_untouched: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> (phys_sel[2] != '0));

    a_r1_globals_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_addr_a < 5'd8) |-> (rd_phys[0] == PW'(rd_addr_a)));
endmodule

// File: tb/wrf_top_tb_top.sv
module wrf_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NWIN = 8;
    localparam int XLEN = 32;
    localparam int CW   = $clog2(NWIN);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [4:0]      rd_addr_a = '0, rd_addr_b = '0, wr_addr = '0;
    logic [XLEN-1:0] rd_data_a, rd_data_b, wr_data = '0;
    logic            wr_en = 1'b0, save_i = 1'b0, restore_i = 1'b0;
    logic [NWIN-1:0] wim_i = '0;
    logic [CW-1:0]   cwp_o;
    logic            ovf_o, unf_o;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    int              q_kind[$];
    logic [XLEN-1:0] q_exp[$];
    string           q_tag[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    wrf_top #(.NWIN(NWIN), .XLEN(XLEN)) dut_i (
        .clk(clk), .rst_n(rst_n), .rd_addr_a(rd_addr_a), .rd_data_a(rd_data_a),
        .rd_addr_b(rd_addr_b), .rd_data_b(rd_data_b), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .save_i(save_i),
        .restore_i(restore_i), .wim_i(wim_i), .cwp_o(cwp_o),
        .ovf_o(ovf_o), .unf_o(unf_o)
    );

    // kinds: 0 port A, 1 port B, 2 pointer, 3 overflow, 4 underflow
    task automatic expect_item(int kind, logic [XLEN-1:0] exp, string tag);
        q_kind.push_back(kind);
        q_exp.push_back(exp);
        q_tag.push_back(tag);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 1'b0; save_i = 1'b0; restore_i = 1'b0;
        rd_addr_a = '0; rd_addr_b = '0;
    endtask

    task automatic wr(logic [4:0] a, logic [XLEN-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        tick();
    endtask

    task automatic rd_a(logic [4:0] a, logic [XLEN-1:0] e, string tag);
        rd_addr_a = a;
        expect_item(0, e, tag);
        tick();
    endtask

    task automatic flags(int cwp_e, bit ov, bit un, string tag);
        expect_item(2, XLEN'(cwp_e), tag);
        expect_item(3, XLEN'(ov), tag);
        expect_item(4, XLEN'(un), tag);
        tick();
    endtask

    // monitor: compares everything queued for this cycle
    always @(negedge clk) begin
        while (q_kind.size() > 0) begin
            automatic int              k   = q_kind.pop_front();
            automatic logic [XLEN-1:0] e   = q_exp.pop_front();
            automatic string           t   = q_tag.pop_front();
            automatic logic [XLEN-1:0] act;
            case (k)
                0: act = rd_data_a;
                1: act = rd_data_b;
                2: act = XLEN'(cwp_o);
                3: act = XLEN'(ovf_o);
                default: act = XLEN'(unf_o);
            endcase
            checks++;
            if (act !== e) begin
                errors++;
                $display("FAIL %s kind %0d actual %h expected %h", t, k, act, e);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R10 reset state
        rd_addr_a = 5'd9;  expect_item(0, '0, "R10");
        rd_addr_b = 5'd30; expect_item(1, '0, "R10");
        flags(0, 0, 0, "R10");
        // globals
        for (int i = 0; i < 8; i++) wr(5'(i), 32'h1000 + i);
        // R2 zero register, R1 global visible
        rd_addr_a = 5'd0; expect_item(0, '0, "R2");
        rd_addr_b = 5'd3; expect_item(1, 32'h1003, "R1");
        tick();
        // R8 bypass on port A (global) and port B (local)
        wr_en = 1; wr_addr = 5'd5; wr_data = 32'hB0B0_0005;
        rd_addr_a = 5'd5; expect_item(0, 32'hB0B0_0005, "R8");
        tick();
        wr_en = 1; wr_addr = 5'd17; wr_data = 32'hB0B0_0017;
        rd_addr_b = 5'd17; expect_item(1, 32'hB0B0_0017, "R8");
        tick();
        // caller outs and a local in window 0
        for (int i = 0; i < 8; i++) wr(5'(8 + i), 32'h200 + i);
        wr(5'd16, 32'hCAFE_0016);
        // save from 0 wraps to 7
        save_i = 1; tick();
        flags(NWIN - 1, 0, 0, "R3");
        for (int i = 0; i < 8; i++) rd_a(5'(24 + i), 32'h200 + i, "R4");
        rd_a(5'd16, '0, "R5");
        rd_a(5'd3, 32'h1003, "R1");
        wr(5'd24, 32'hAAAA_0024);
        wr(5'd16, 32'hBBBB_0016);
        // restore back to 0
        restore_i = 1; tick();
        flags(0, 0, 0, "R3");
        rd_a(5'd8, 32'hAAAA_0024, "R4");
        rd_a(5'd16, 32'hCAFE_0016, "R5");
        rd_a(5'd17, 32'hB0B0_0017, "R5");
        // R6 overflow: window 7 marked
        wim_i = 8'h80; save_i = 1; tick();
        flags(0, 1, 0, "R6");
        flags(0, 0, 0, "R6");
        // R7 underflow: window 1 marked
        wim_i = 8'h02; restore_i = 1; tick();
        flags(0, 0, 1, "R7");
        flags(0, 0, 0, "R7");
        // R2 write to index 0 ignored
        wim_i = '0;
        wr(5'd0, 32'hDEAD_BEEF);
        rd_a(5'd0, '0, "R2");
        // R9 save and restore together
        save_i = 1; restore_i = 1; tick();
        flags(0, 0, 0, "R9");
        // two saves then one restore
        save_i = 1; tick();
        save_i = 1; tick();
        flags(6, 0, 0, "R3");
        rd_a(5'd3, 32'h1003, "R1");
        restore_i = 1; tick();
        flags(7, 0, 0, "R3");
        rd_a(5'd16, 32'hBBBB_0016, "R5");
        tick();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule